// File: doc/BRIEF.md
# Residue-Checked Modulo 2^n+1 Multiplier

This block multiplies two operands modulo 2^n+1 and checks its own result online with a residue code. The default is n = 16. Each operand is an (n+1)-bit value from 0 to 2^n, and the value 2^n stands for -1. The check base is 2^c-1, with c = 4 by default, which gives modulus 15.

A residue generator reduces a word modulo 15. It cuts the word into 4-bit slices and adds the slices with end-around carry. Because 2^n+1 is not a multiple of 15, the product residue cannot be predicted from the operand residues alone. The check is therefore split in two:

- The first comparison tests the raw double-width product. The product of the operand residues must equal the residue of the high half plus the residue of the low half.
- The second comparison tests the modular reduction. The residue of the delivered result must equal the low-half residue minus the high-half residue, plus 2 when the reduction wrapped.

In each comparison, one side is inverted bit by bit. The resulting bit pairs feed a tree of two-rail checker cells. The block ends in a pair of wires. A complementary pair means no error. An equal pair means an error was detected, either in the data or in the checker itself.

A fault-injection mask lets a testbench flip bits of the product at the point where it leaves the block. The same corrupted word is the one that is checked.

Top module: `rc_selfcheck_mul`

## Requirements
- R1: The `prod` output equals op_a·op_b mod (2^16+1). It appears two rising clock edges after the operands are presented.
- R2: Operands span 0 to 65536, and 65536 acts as -1. For example, 65536·65536 gives 1 and 65536·2 gives 65535. `prod` never exceeds 65536.
- R3: Residues are formed by adding 4-bit slices with end-around carry. The residue 15 compares equal to 0. A zero product, whose two sides reduce to 0 and 15, must not raise an error.
- R4: With `flip_mask` at zero, `chk_hi` and `chk_lo` are always complementary, meaning no error.
- R5: A one-hot `flip_mask` on any of bits 0..15 has two effects in the same output cycle. `prod` shows the correct product XOR the mask, and `chk_hi` equals `chk_lo`, meaning an error.
- R6: While `rst_n` is low, `prod` is 0, `chk_hi` is 1 and `chk_lo` is 0, whatever the inputs are.
- R7: A product whose low half is smaller than its high half is reduced correctly, for example 1·65536 gives 65536 and 2·65536 gives 65535. Such a product raises no error.
- R8: Flipping bit 16 of the product, which has residue weight 1, is detected in the same way as in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 17 | First operand, 0..2^16 |
| op_b | input | 17 | Second operand, 0..2^16 |
| flip_mask | input | 17 | Test-only XOR mask applied to the product before output and check |
| prod | output | 17 | Product modulo 2^16+1 |
| chk_hi | output | 1 | Two-rail check output, first wire |
| chk_lo | output | 1 | Two-rail check output, second wire |

## Verification
The product-array comparison and the reduction comparison are resolved in the same cycle and merged in one rail tree. Every vector therefore exercises both at once.

The bench provokes the awkward overlaps directly:
- a wrapped reduction, where the plus-2 correction enters the second comparison;
- a zero product, where one comparison sees 15 against 0;
- single-bit faults injected on cycles next to clean ones.

In each output cycle the bench judges the product value and the rail pair together against a queue-based model. The model expects an equal rail pair exactly when a mask bit was set two cycles earlier.

// File: rtl/rc_pkg.sv
package rc_pkg;

   // Two-wire check code: complementary means healthy.
   typedef struct packed {
      logic hi;
      logic lo;
   } rail_t;

   localparam rail_t RAIL_IDLE = '{hi: 1'b1, lo: 1'b0};

   // Two-rail checker cell: two complementary inputs give a complementary
   // output; any non-complementary input forces a non-complementary output.
   function automatic rail_t rail_merge(input rail_t x, input rail_t y);
      rail_t z;
      z.hi = (x.hi & y.hi) | (x.lo & y.lo);
      z.lo = (x.hi & y.lo) | (x.lo & y.hi);
      return z;
   endfunction

endpackage

// File: rtl/rc_eac_add.sv
module rc_eac_add #(
   parameter int C = 4
) (
   input  logic [C-1:0] a,
   input  logic [C-1:0] b,
   output logic [C-1:0] s
);
   logic [C:0] raw;

   // Carry out of the top slice re-enters at weight 1 (2^C == 1 mod 2^C-1).
   always_comb begin
      raw = {1'b0, a} + {1'b0, b};
      s   = raw[C-1:0] + {{(C-1){1'b0}}, raw[C]};
   end
endmodule

// File: rtl/rc_residue.sv
module rc_residue #(
   parameter int W         = 17,
   parameter int C         = 4,
   parameter bit FOLD_TREE = 1'b1
) (
   input  logic [W-1:0] x,
   output logic [C-1:0] r
);
   localparam int S  = (W + C - 1) / C;
   localparam int SW = S * C;
   localparam int LV = (S > 1) ? $clog2(S) : 1;
   localparam int P2 = 1 << LV;

   logic [SW-1:0]         padded;
   logic [S-1:0][C-1:0]   slice;

   always_comb begin
      padded        = '0;
      padded[W-1:0] = x;
   end

   for (genvar i = 0; i < S; i++) begin : g_slice
      assign slice[i] = padded[i*C +: C];
   end

   if (FOLD_TREE) begin : g_tree
      // Balanced fold: depth log2(slices) end-around adders.
      logic [2*P2-2:0][C-1:0] node;
      for (genvar i = 0; i < P2; i++) begin : g_leaf
         if (i < S) begin : g_used
            assign node[P2-1+i] = slice[i];
         end else begin : g_pad
            assign node[P2-1+i] = '0;
         end
      end
      for (genvar j = 0; j < P2-1; j++) begin : g_node
         rc_eac_add #(.C(C)) u_add (
            .a(node[2*j+1]),
            .b(node[2*j+2]),
            .s(node[j])
         );
      end
      assign r = node[0];
   end else begin : g_chain
      // Linear fold: fewer adders wired in a ripple of slice count.
      logic [S-1:0][C-1:0] acc;
      assign acc[0] = slice[0];
      for (genvar i = 1; i < S; i++) begin : g_step
         rc_eac_add #(.C(C)) u_add (
            .a(acc[i-1]),
            .b(slice[i]),
            .s(acc[i])
         );
      end
      assign r = acc[S-1];
   end
endmodule

// File: rtl/rc_modmul.sv
module rc_modmul #(
   parameter int N = 16
) (
   input  logic [N:0]   a,
   input  logic [N:0]   b,
   output logic [N:0]   hi,
   output logic [N-1:0] lo,
   output logic         wrap,
   output logic [N:0]   prod
);
   localparam int PW = 2*N + 1;
   localparam logic [N+1:0] MODV = (N+2)'((64'd1 << N) + 64'd1);

   logic [PW-1:0] full;
   logic [N+1:0]  ext;

   // a*b = hi*2^N + lo, and 2^N == -1, so result = lo - hi (+ modulus on wrap).
   always_comb begin
      full = PW'(a) * PW'(b);
      lo   = full[N-1:0];
      hi   = full[2*N:N];
      wrap = ({1'b0, lo} < hi);
      ext  = {2'b00, lo} - {1'b0, hi} + (wrap ? MODV : '0);
      prod = ext[N:0];
   end
endmodule

// File: rtl/rc_rail_tree.sv
module rc_rail_tree #(
   parameter int PAIRS = 8
) (
   input  rc_pkg::rail_t [PAIRS-1:0] pairs,
   output rc_pkg::rail_t             z
);
   import rc_pkg::*;

   localparam int LV = (PAIRS > 1) ? $clog2(PAIRS) : 1;
   localparam int P2 = 1 << LV;

   rail_t [2*P2-2:0] node;

   for (genvar i = 0; i < P2; i++) begin : g_leaf
      if (i < PAIRS) begin : g_used
         assign node[P2-1+i] = pairs[i];
      end else begin : g_pad
         assign node[P2-1+i] = RAIL_IDLE;
      end
   end

   for (genvar j = 0; j < P2-1; j++) begin : g_cell
      assign node[j] = rail_merge(node[2*j+1], node[2*j+2]);
   end

   assign z = node[0];
endmodule

// File: rtl/rc_selfcheck_mul.sv
module rc_selfcheck_mul #(
   parameter int N         = 16,
   parameter int C         = 4,
   parameter bit FOLD_TREE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [N:0] op_a,
   input  logic [N:0] op_b,
   input  logic [N:0] flip_mask,
   output logic [N:0] prod,
   output logic       chk_hi,
   output logic       chk_lo
);
   import rc_pkg::*;

   localparam int OW    = N + 1;
   localparam int PAIRS = 2 * C;

   if (C < 3) begin : g_bad_c
      $error("check width C must be at least 3");
   end
   if (N % C != 0) begin : g_bad_n
      $error("N must be a multiple of C so that 2^N == 1 mod 2^C-1");
   end
   if (N > 31) begin : g_bad_w
      $error("N above 31 is not supported");
   end

   // Stage 1: operand and mask capture
   logic [N:0] a_q, b_q, m_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
         m_q <= '0;
      end else begin
         a_q <= op_a;
         b_q <= op_b;
         m_q <= flip_mask;
      end
   end

   // Unchecked arithmetic path
   logic [N:0]   hi_w, p_w, p_obs;
   logic [N-1:0] lo_w;
   logic         wrap_w;

   rc_modmul #(.N(N)) u_mul (
      .a   (a_q),
      .b   (b_q),
      .hi  (hi_w),
      .lo  (lo_w),
      .wrap(wrap_w),
      .prod(p_w)
   );

   assign p_obs = p_w ^ m_q;

   // Residue generators
   logic [C-1:0] r_a, r_b, r_h, r_l, r_p, r_ab;
   logic [2*C-1:0] ab_raw;

   rc_residue #(.W(OW), .C(C), .FOLD_TREE(FOLD_TREE)) u_res_a (.x(a_q),   .r(r_a));
   rc_residue #(.W(OW), .C(C), .FOLD_TREE(FOLD_TREE)) u_res_b (.x(b_q),   .r(r_b));
   rc_residue #(.W(OW), .C(C), .FOLD_TREE(FOLD_TREE)) u_res_h (.x(hi_w),  .r(r_h));
   rc_residue #(.W(N),  .C(C), .FOLD_TREE(FOLD_TREE)) u_res_l (.x(lo_w),  .r(r_l));
   rc_residue #(.W(OW), .C(C), .FOLD_TREE(FOLD_TREE)) u_res_p (.x(p_obs), .r(r_p));

   assign ab_raw = (2*C)'(r_a) * (2*C)'(r_b);
   rc_residue #(.W(2*C), .C(C), .FOLD_TREE(FOLD_TREE)) u_res_ab (.x(ab_raw), .r(r_ab));

   // Comparison 1 operand: residue of hi + lo
   logic [C-1:0] sum_hl;
   rc_eac_add #(.C(C)) u_sum_hl (.a(r_h), .b(r_l), .s(sum_hl));

   // Comparison 2 operand: lo - hi + 2*wrap (one's complement negates mod 2^C-1)
   logic [C-1:0] dif_lh, wrap2, pred_p;
   assign wrap2 = {{(C-2){1'b0}}, wrap_w, 1'b0};
   rc_eac_add #(.C(C)) u_dif (.a(r_l),    .b(~r_h),  .s(dif_lh));
   rc_eac_add #(.C(C)) u_cor (.a(dif_lh), .b(wrap2), .s(pred_p));

   // All-ones is the second encoding of zero
   function automatic logic [C-1:0] canon(input logic [C-1:0] v);
      return (&v) ? '0 : v;
   endfunction

   logic [C-1:0] n_ab, n_hl, n_p, n_pred;
   assign n_ab   = canon(r_ab);
   assign n_hl   = canon(sum_hl);
   assign n_p    = canon(r_p);
   assign n_pred = canon(pred_p);

   // Dual-rail compare: one copy inverted, pairs complementary when equal
   rail_t [PAIRS-1:0] pairs;
   for (genvar i = 0; i < C; i++) begin : g_pair
      assign pairs[i]     = '{hi: n_ab[i], lo: ~n_hl[i]};
      assign pairs[C + i] = '{hi: n_p[i],  lo: ~n_pred[i]};
   end

   rail_t z_w;
   rc_rail_tree #(.PAIRS(PAIRS)) u_tree (.pairs(pairs), .z(z_w));

   // Stage 2: product and check code leave together
   rail_t rail_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod   <= '0;
         rail_q <= RAIL_IDLE;
      end else begin
         prod   <= p_obs;
         rail_q <= z_w;
      end
   end

   assign chk_hi = rail_q.hi;
   assign chk_lo = rail_q.lo;
endmodule

// File: rtl/rc_selfcheck_mul_chk.sv
module rc_selfcheck_mul_chk #(
   parameter int N = 16
) (
   input logic       clk,
   input logic       rst_n,
   input logic [N:0] a_s1,
   input logic [N:0] b_s1,
   input logic [N:0] mask_s1,
   input logic [N:0] prod,
   input logic       rail_hi,
   input logic       rail_lo
);
   localparam logic [N:0] TOPV = (N+1)'(64'd1 << N);

   function automatic logic [N:0] mod_ref(input logic [N:0] x, input logic [N:0] y);
      longint unsigned t;
      t = (64'(x) * 64'(y)) % ((64'd1 << N) + 64'd1);
      return (N+1)'(t);
   endfunction

   // R1
   prod_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_s1 == '0) |=> (prod == mod_ref($past(a_s1), $past(b_s1))));

   // R2
   prod_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_s1 == '0) |=> (prod <= TOPV));

   // R4
   clean_rails_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_s1 == '0) |=> (rail_hi != rail_lo));

   // R5
   flip_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(mask_s1) == 1) |=> (rail_hi == rail_lo));

   // R6
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (prod == '0 && rail_hi && !rail_lo));
endmodule

bind rc_selfcheck_mul rc_selfcheck_mul_chk #(.N(N)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .a_s1   (a_q),
   .b_s1   (b_q),
   .mask_s1(m_q),
   .prod   (prod),
   .rail_hi(chk_hi),
   .rail_lo(chk_lo)
);

// File: tb/rc_selfcheck_mul_tb_top.sv
`timescale 1ns/1ps
module rc_selfcheck_mul_tb_top;
   localparam int N = 16;
   localparam longint unsigned MODV = (64'd1 << N) + 64'd1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [N:0] op_a = '0;
   logic [N:0] op_b = '0;
   logic [N:0] flip_mask = '0;
   logic [N:0] prod;
   logic       chk_hi, chk_lo;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct {
      logic [N:0] p;
      bit         err;
      int         rq;
   } exp_t;

   exp_t pend[$];

   always #2 clk = ~clk;

   rc_selfcheck_mul dut_i (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
      .flip_mask(flip_mask), .prod(prod), .chk_hi(chk_hi), .chk_lo(chk_lo)
   );

   function automatic logic [N:0] ref_mul(input logic [N:0] x, input logic [N:0] y);
      longint unsigned t;
      t = (64'(x) * 64'(y)) % MODV;
      return (N+1)'(t);
   endfunction

   task automatic check(input bit ok, input int rq, input string what,
                        input longint unsigned act, input longint unsigned expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL R%0d %s: actual %0d expected %0d", rq, what, act, expv);
      end
   endtask

   // One cycle: compare the entry due now, then present the next vector.
   task automatic step(input logic [N:0] a, input logic [N:0] b,
                       input logic [N:0] m, input int rq);
      exp_t e;
      @(negedge clk);
      if (pend.size() == 2) begin
         e = pend.pop_front();
         check(prod == e.p, e.rq, "product", prod, e.p);
         check((chk_hi == chk_lo) == e.err, e.rq, "error rail (1=equal pair)",
               longint'(chk_hi == chk_lo), longint'(e.err));
      end
      op_a = a;
      op_b = b;
      flip_mask = m;
      e.p = ref_mul(a, b) ^ m;
      e.err = (m != '0);
      e.rq = rq;
      pend.push_back(e);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R6: reset holds outputs regardless of inputs
      op_a = 17'd12345;
      op_b = 17'd999;
      flip_mask = 17'h00010;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(prod == '0, 6, "prod in reset", prod, 0);
         check(chk_hi == 1'b1 && chk_lo == 1'b0, 6, "rails in reset",
               {chk_hi, chk_lo}, 2);
      end
      @(negedge clk);
      rst_n = 1'b1;
      op_a = '0;
      op_b = '0;
      flip_mask = '0;

      // R2: the value 2^16 acts as -1
      step(17'd65536, 17'd65536, '0, 2);
      step(17'd65536, 17'd2,     '0, 2);
      step(17'd65535, 17'd65535, '0, 2);
      // R7: low half below high half forces the wrap correction
      step(17'd1,     17'd65536, '0, 7);
      step(17'd2,     17'd65536, '0, 7);
      step(17'd40000, 17'd50000, '0, 7);
      // R3: zero product sees 0 against 15 in the reduction compare
      step(17'd0,     17'd12345, '0, 3);
      step(17'd0,     17'd0,     '0, 3);
      step(17'd15,    17'd16,    '0, 3);
      step(17'd30,    17'd1,     '0, 3);

      // R1 and R4: clean random traffic
      for (int i = 0; i < 400; i++) begin
         step((N+1)'($urandom % MODV), (N+1)'($urandom % MODV), '0, 1);
      end

      // R5: single-bit faults on bits 0..15, next to clean cycles
      for (int bitn = 0; bitn < N; bitn++) begin
         for (int k = 0; k < 3; k++) begin
            step((N+1)'($urandom % MODV), (N+1)'($urandom % MODV),
                 (N+1)'(1) << bitn, 5);
            step((N+1)'($urandom % MODV), (N+1)'($urandom % MODV), '0, 4);
         end
      end

      // R8: fault on the top bit, including corner operands
      step(17'd65536, 17'd1,     17'h10000, 8);
      step(17'd0,     17'd0,     17'h10000, 8);
      for (int k = 0; k < 6; k++) begin
         step((N+1)'($urandom % MODV), (N+1)'($urandom % MODV), 17'h10000, 8);
      end

      // flush the two in-flight entries
      step('0, '0, '0, 4);
      step('0, '0, '0, 4);
      step('0, '0, '0, 4);

      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule